// File: doc/BRIEF.md
# Programmable Raster Sync Generator

This block produces the horizontal sync, vertical sync, data-enable and per-pixel fetch strobes for a parallel RGB panel, and presents the memory base address of the frame being scanned. Every count is held in a small bank of 32-bit control words on a single-cycle write/read bus. Software programs the line and frame geometry, the polarities and a base address, then sets a run bit. The counters then sweep the raster until run is cleared.

Blanking is given as wait counts measured from the leading edge of sync rather than as porch values. The fetch window (transfer count) and the data-enable window (valid count) are programmed separately. The base address is double-buffered: software writes a pending address at any time, and the generator copies it into the in-use address only when a frame starts. Clearing run lets the current frame complete. A soft-reset bit returns the block to its reset state, and a gate bit freezes the raster in place.

Register words sit every 16 bytes (bus_addr[7:4] selects the word). Sub-address 0x0 writes the whole word, 0x4 ORs in the written ones, 0x8 clears the written ones, and 0xC, or any address with bits [1:0] not zero, is ignored. Word 0 holds control: bit 0 run, bit 30 gate, bit 31 soft reset. Word 1 holds the frame length in lines [15:0]. Word 2 holds the line period in clocks [17:0] and the hsync width in clocks [31:18]. Word 3 holds the horizontal wait [27:16] and the vertical wait [15:0]. Word 4 holds the transfer count: vertical [31:16] and horizontal [15:0]. Word 5 holds the valid pixels per line [17:0]. Word 6 holds the vsync width in lines [15:0], hsync active-high (24), vsync active-high (25), data-enable active-high (26), falling sample edge (27) and sync outputs on (28). Word 7 is the pending base address. Word 8 is the in-use base address (read-only). Word 9 bit 0 reads 1 while the raster runs.

Top module: `disp_timing_gen`

## Requirements
- R1: A write at sub-address 0x0 replaces a word, 0x4 sets only the bits written as 1, 0x8 clears only the bits written as 1, and 0xC leaves the word unchanged. Reads return the word at bus_addr[7:4] regardless of the sub-address.
- R2: While running, horizontal position h counts 0 to period-1 and wraps. hsync is asserted for h < hsync width.
- R3: Vertical position v advances on each line wrap and wraps after frame-length lines. vsync is asserted for v < vsync width.
- R4: Data enable is asserted when hwait <= h < hwait+valid and vwait <= v < vwait+vertical transfer count.
- R5: pix_req is high when hwait <= h < hwait+horizontal transfer count, within the same vertical window as R4. It follows neither sync-on nor polarity.
- R6: Each of hsync, vsync and data enable is high when asserted if its active-high bit is 1, and low when asserted otherwise. An output that is not asserted sits at the opposite level.
- R7: While sync-on is 0, hsync, vsync and data enable stay at their inactive levels, and the counters and pix_req keep running.
- R8: The in-use base (frame_base and word 8) takes the pending base only on the cycle a frame starts. A pending write landing on that same edge is used at the following frame.
- R9: Setting run starts a frame on the next cycle. Clearing run lets the frame finish, after which the status bit reads 0, pix_req is 0, and the strobes go inactive.
- R10: While the gate bit is 1, the raster position and all strobes hold.
- R11: While soft reset is 1, every word except control reads 0, the raster is idle and frame_base is 0.
- R12: After rst_n, all words read 0, frame_base is 0, pix_req is 0, and hsync, vsync and data enable are high (inactive for active-low).
- R13: sample_fall follows bit 27 of word 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the control bus |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| lcd_hsync | output | 1 | Line sync at programmed polarity |
| lcd_vsync | output | 1 | Frame sync at programmed polarity |
| lcd_de | output | 1 | Data enable at programmed polarity |
| pix_req | output | 1 | Per-pixel fetch request, active high |
| sample_fall | output | 1 | Panel samples on the falling clock edge |
| frame_base | output | 32 | Base address of the frame being scanned |

## Verification
Two functions can meet on one edge: the frame-start reload of the in-use base, and a bus write to the pending base. The bench places a pending-base write so that it is registered on the exact edge where the raster wraps to line 0, column 0. It then expects the old pending value to appear in frame_base for the new frame and the freshly written value only one frame later. The same continuous sweep also meets a run clear in the middle of a frame. It expects the raster to keep running up to the last pixel of that frame and the status bit to fall on the following cycle.

// File: rtl/disp_tg_pkg.sv
package disp_tg_pkg;
    localparam int DW      = 32;
    localparam int LINE_W  = 18;
    localparam int FRAME_W = 16;
    localparam int HSW_W   = 14;
    localparam int HWAIT_W = 12;
    localparam int NREG_RW = 8;

    // word indices (bus_addr[7:4])
    localparam int IDX_CTRL   = 0;
    localparam int IDX_FRAME  = 1;
    localparam int IDX_LINE   = 2;
    localparam int IDX_WAIT   = 3;
    localparam int IDX_XFER   = 4;
    localparam int IDX_VALID  = 5;
    localparam int IDX_SYNC   = 6;
    localparam int IDX_NEXT   = 7;
    localparam int IDX_CUR    = 8;
    localparam int IDX_STATUS = 9;

    // control bits
    localparam int B_RUN  = 0;
    localparam int B_GATE = 30;
    localparam int B_SRST = 31;
    // sync word bits
    localparam int B_HS_HI = 24;
    localparam int B_VS_HI = 25;
    localparam int B_DE_HI = 26;
    localparam int B_FALL  = 27;
    localparam int B_SYNC_ON = 28;

    typedef enum logic { ST_IDLE, ST_RUN } tg_state_e;

    typedef struct packed {
        logic               run;
        logic               gate;
        logic               srst;
        logic               sync_on;
        logic               hs_hi;
        logic               vs_hi;
        logic               de_hi;
        logic               fall;
        logic [FRAME_W-1:0] frame_len;
        logic [FRAME_W-1:0] vsw;
        logic [FRAME_W-1:0] vwait;
        logic [FRAME_W-1:0] vcount;
        logic [LINE_W-1:0]  line_len;
        logic [LINE_W-1:0]  valid;
        logic [HSW_W-1:0]   hsw;
        logic [HWAIT_W-1:0] hwait;
        logic [15:0]        hcount;
        logic [DW-1:0]      next_base;
    } tg_cfg_t;
endpackage

// File: rtl/disp_tg_regs.sv
module disp_tg_regs
    import disp_tg_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] cur_base,
    input  logic          active,
    output tg_cfg_t       cfg
);
    localparam int IDX_LSB = 4;
    localparam int IDX_W   = 4;
    localparam int SEL_W   = $clog2(NREG_RW);

    typedef struct packed {
        logic [NREG_RW-1:0][DW-1:0] r;
    } regs_s;

    regs_s regs_d, regs_q;

    logic [IDX_W-1:0] idx;
    logic [1:0]       op;
    logic             aligned;
    logic             wr_hit;

    assign idx     = bus_addr[IDX_LSB +: IDX_W];
    assign op      = bus_addr[3:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_hit  = bus_wr && aligned && (idx < IDX_W'(NREG_RW));

    always_comb begin
        regs_d = regs_q;
        if (wr_hit) begin
            unique case (op)
                2'd0: regs_d.r[idx[SEL_W-1:0]] = bus_wdata;
                2'd1: regs_d.r[idx[SEL_W-1:0]] = regs_q.r[idx[SEL_W-1:0]] | bus_wdata;
                2'd2: regs_d.r[idx[SEL_W-1:0]] = regs_q.r[idx[SEL_W-1:0]] & ~bus_wdata;
                default: ;
            endcase
        end
        if (regs_q.r[IDX_CTRL][B_SRST]) begin
            for (int i = 1; i < NREG_RW; i++) begin
                regs_d.r[i] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (idx < IDX_W'(NREG_RW))            bus_rdata = regs_q.r[idx[SEL_W-1:0]];
        else if (idx == IDX_W'(IDX_CUR))      bus_rdata = cur_base;
        else if (idx == IDX_W'(IDX_STATUS))   bus_rdata = {{(DW-1){1'b0}}, active};
    end

    always_comb begin
        cfg.run       = regs_q.r[IDX_CTRL][B_RUN];
        cfg.gate      = regs_q.r[IDX_CTRL][B_GATE];
        cfg.srst      = regs_q.r[IDX_CTRL][B_SRST];
        cfg.frame_len = regs_q.r[IDX_FRAME][FRAME_W-1:0];
        cfg.line_len  = regs_q.r[IDX_LINE][LINE_W-1:0];
        cfg.hsw       = regs_q.r[IDX_LINE][LINE_W +: HSW_W];
        cfg.hwait     = regs_q.r[IDX_WAIT][16 +: HWAIT_W];
        cfg.vwait     = regs_q.r[IDX_WAIT][FRAME_W-1:0];
        cfg.vcount    = regs_q.r[IDX_XFER][31:16];
        cfg.hcount    = regs_q.r[IDX_XFER][15:0];
        cfg.valid     = regs_q.r[IDX_VALID][LINE_W-1:0];
        cfg.vsw       = regs_q.r[IDX_SYNC][FRAME_W-1:0];
        cfg.hs_hi     = regs_q.r[IDX_SYNC][B_HS_HI];
        cfg.vs_hi     = regs_q.r[IDX_SYNC][B_VS_HI];
        cfg.de_hi     = regs_q.r[IDX_SYNC][B_DE_HI];
        cfg.fall      = regs_q.r[IDX_SYNC][B_FALL];
        cfg.sync_on   = regs_q.r[IDX_SYNC][B_SYNC_ON];
        cfg.next_base = regs_q.r[IDX_NEXT];
    end

    // R1
    set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(8'h64) && !regs_q.r[IDX_CTRL][B_SRST])
        |=> ((regs_q.r[IDX_SYNC] & $past(bus_wdata)) == $past(bus_wdata)));

    // R1
    clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(8'h68))
        |=> ((regs_q.r[IDX_SYNC] & $past(bus_wdata)) == '0));

    // R11
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.r[IDX_CTRL][B_SRST] |=> (regs_q.r[IDX_FRAME] == '0));
endmodule

// File: rtl/disp_tg_core.sv
module disp_tg_core
    import disp_tg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  tg_cfg_t       cfg,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          pix_req,
    output logic          sample_fall,
    output logic          active,
    output logic [DW-1:0] frame_base
);
    localparam int HX = LINE_W + 1;
    localparam int VX = FRAME_W + 1;

    typedef struct packed {
        tg_state_e          st;
        logic [LINE_W-1:0]  h;
        logic [FRAME_W-1:0] v;
        logic [DW-1:0]      cur;
    } core_s;

    core_s core_d, core_q;

    logic running, h_last, v_last;
    logic v_win, h_de_win, h_fetch_win;
    logic hs_act, vs_act, de_act;

    assign running = (core_q.st == ST_RUN);
    assign h_last  = (HX'(core_q.h) + HX'(1)) >= HX'(cfg.line_len);
    assign v_last  = (VX'(core_q.v) + VX'(1)) >= VX'(cfg.frame_len);

    always_comb begin
        core_d = core_q;
        if (cfg.srst) begin
            core_d = '{st: ST_IDLE, h: '0, v: '0, cur: '0};
        end else if (!cfg.gate) begin
            unique case (core_q.st)
                ST_IDLE: begin
                    if (cfg.run) begin
                        core_d.st  = ST_RUN;
                        core_d.h   = '0;
                        core_d.v   = '0;
                        core_d.cur = cfg.next_base;
                    end
                end
                ST_RUN: begin
                    if (h_last) begin
                        core_d.h = '0;
                        if (v_last) begin
                            core_d.v = '0;
                            if (cfg.run) core_d.cur = cfg.next_base;
                            else         core_d.st  = ST_IDLE;
                        end else begin
                            core_d.v = core_q.v + FRAME_W'(1);
                        end
                    end else begin
                        core_d.h = core_q.h + LINE_W'(1);
                    end
                end
                default: core_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '{st: ST_IDLE, h: '0, v: '0, cur: '0};
        else        core_q <= core_d;
    end

    always_comb begin
        v_win       = (VX'(core_q.v) >= VX'(cfg.vwait)) &&
                      (VX'(core_q.v) <  VX'(cfg.vwait) + VX'(cfg.vcount));
        h_de_win    = (HX'(core_q.h) >= HX'(cfg.hwait)) &&
                      (HX'(core_q.h) <  HX'(cfg.hwait) + HX'(cfg.valid));
        h_fetch_win = (HX'(core_q.h) >= HX'(cfg.hwait)) &&
                      (HX'(core_q.h) <  HX'(cfg.hwait) + HX'(cfg.hcount));
        hs_act  = running && cfg.sync_on && (core_q.h < LINE_W'(cfg.hsw));
        vs_act  = running && cfg.sync_on && (core_q.v < cfg.vsw);
        de_act  = running && cfg.sync_on && v_win && h_de_win;
        hsync   = cfg.hs_hi ? hs_act : !hs_act;
        vsync   = cfg.vs_hi ? vs_act : !vs_act;
        de      = cfg.de_hi ? de_act : !de_act;
        pix_req = running && v_win && h_fetch_win;
    end

    assign sample_fall = cfg.fall;
    assign active      = running;
    assign frame_base  = core_q.cur;

    // R2
    line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cfg.gate && !cfg.srst && h_last) |=> (core_q.h == '0));

    // R3
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cfg.gate && !cfg.srst && h_last && !v_last)
        |=> (core_q.v == $past(core_q.v) + FRAME_W'(1)));

    // R8
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && !(core_q.h == '0 && core_q.v == '0))
        |-> $stable(core_q.cur));

    // R9
    stop_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cfg.run && !cfg.gate && !cfg.srst && !(h_last && v_last))
        |=> running);

    // R10
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.gate && !cfg.srst) |=> ($stable(core_q.h) && $stable(core_q.v)));
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import disp_tg_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          lcd_hsync,
    output logic          lcd_vsync,
    output logic          lcd_de,
    output logic          pix_req,
    output logic          sample_fall,
    output logic [31:0]   frame_base
);
    tg_cfg_t cfg;
    logic    active;

    disp_tg_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cur_base  (frame_base),
        .active    (active),
        .cfg       (cfg)
    );

    disp_tg_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg         (cfg),
        .hsync       (lcd_hsync),
        .vsync       (lcd_vsync),
        .de          (lcd_de),
        .pix_req     (pix_req),
        .sample_fall (sample_fall),
        .active      (active),
        .frame_base  (frame_base)
    );
endmodule

// File: tb/disp_timing_gen_tb.sv
module disp_timing_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h90;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        lcd_hsync, lcd_vsync, lcd_de, pix_req, sample_fall;
    logic [31:0] frame_base;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    disp_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lcd_hsync(lcd_hsync),
        .lcd_vsync(lcd_vsync), .lcd_de(lcd_de), .pix_req(pix_req),
        .sample_fall(sample_fall), .frame_base(frame_base)
    );

    // geometry used by the sweep
    localparam int LP = 10, HSW = 2, HW = 4, VAL = 3, HC = 2;
    localparam int FL = 7, VSW = 1, VW = 2, VC = 3;
    localparam logic [31:0] SYNC_A = 32'h1500_0001; // on, de_hi, hs_hi
    localparam logic [31:0] SYNC_B = 32'h1200_0001; // on, vs_hi
    localparam logic [31:0] SYNC_B_OFF = 32'h0200_0001;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h90;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 8'h90;
        #1;
    endtask

    function automatic logic lvl(input logic act, input logic hi);
        return hi ? act : !act;
    endfunction

    initial begin
        #100000;
        fails++; checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        logic hs_hi, vs_hi, de_hi, son, wr_prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(lcd_hsync && lcd_vsync && lcd_de, "R12 strobes",
            {lcd_hsync, lcd_vsync, lcd_de}, 3'b111);
        chk(!pix_req && frame_base == 0 && !sample_fall, "R12 req/base",
            frame_base, 0);
        rd(8'h10, rv); chk(rv == 0, "R12 frame word", rv, 0);
        rd(8'h90, rv); chk(rv == 0, "R12 status", rv, 0);

        // R1 aliases, R13 edge select
        wr(8'h60, 32'h0000_00F0);
        wr(8'h64, 32'h0800_000F);
        rd(8'h60, rv); chk(rv == 32'h0800_00FF, "R1 set alias", rv, 32'h0800_00FF);
        chk(sample_fall == 1'b1, "R13 edge", sample_fall, 1);
        wr(8'h68, 32'h0000_00F0);
        rd(8'h6C, rv); chk(rv == 32'h0800_000F, "R1 clear alias", rv, 32'h0800_000F);
        wr(8'h6C, 32'hFFFF_FFFF);
        rd(8'h60, rv); chk(rv == 32'h0800_000F, "R1 ignored alias", rv, 32'h0800_000F);
        wr(8'h61, 32'hFFFF_FFFF);
        rd(8'h60, rv); chk(rv == 32'h0800_000F, "R1 unaligned", rv, 32'h0800_000F);
        wr(8'h68, 32'h0800_0000);
        chk(sample_fall == 1'b0, "R13 edge clear", sample_fall, 0);

        // geometry
        wr(8'h10, FL);
        wr(8'h20, (HSW << 18) | LP);
        wr(8'h30, (HW << 16) | VW);
        wr(8'h40, (VC << 16) | HC);
        wr(8'h50, VAL);
        wr(8'h60, SYNC_A);
        wr(8'h70, 32'h0000_1000);
        hs_hi = 1; vs_hi = 0; de_hi = 1; son = 1;
        rd(8'h80, rv); chk(rv == 0, "R8 in-use before run", rv, 0);

        @(negedge clk);
        bus_addr = 8'h00; bus_wdata = 32'h1; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h90;
        wr_prev = 1'b1;

        for (int t = 0; t <= 445; t++) begin
            int m, h, v;
            logic run_exp, hsa, vsa, dea, pra;
            string tg;
            @(negedge clk);
            m = (t <= 363) ? t : ((t <= 378) ? 363 : t - 15);
            h = m % LP;
            v = (m / LP) % FL;
            run_exp = (t <= 434);
            hsa = run_exp && son && (h < HSW);
            vsa = run_exp && son && (v < VSW);
            dea = run_exp && son && v >= VW && v < VW + VC && h >= HW && h < HW + VAL;
            pra = run_exp && v >= VW && v < VW + VC && h >= HW && h < HW + HC;
            if (t < 210)      tg = "R2/R3/R4/R5 sweep";
            else if (t < 280) tg = "R6 polarity";
            else if (t < 350) tg = "R7 sync off";
            else if (t < 363) tg = "R6 polarity restored";
            else if (t < 379) tg = "R10 gate";
            else              tg = "R9 stop";
            chk(lcd_hsync == lvl(hsa, hs_hi), {tg, " hsync"}, lcd_hsync, lvl(hsa, hs_hi));
            chk(lcd_vsync == lvl(vsa, vs_hi), {tg, " vsync"}, lcd_vsync, lvl(vsa, vs_hi));
            chk(lcd_de == lvl(dea, de_hi), {tg, " de"}, lcd_de, lvl(dea, de_hi));
            chk(pix_req == pra, {tg, " pix_req"}, pix_req, pra);
            if (!wr_prev)
                chk(bus_rdata[0] == run_exp, "R9 status", bus_rdata, run_exp);
            if (t == 0 || t == 70)
                chk(frame_base == 32'h1000, "R8 base held", frame_base, 32'h1000);
            if (t == 69)
                chk(frame_base == 32'h1000, "R8 base before wrap", frame_base, 32'h1000);
            if (t == 140)
                chk(frame_base == 32'h2000, "R8 base switched", frame_base, 32'h2000);
            bus_wr = 1'b0; bus_addr = 8'h90;
            case (t)
                69:  begin bus_addr = 8'h70; bus_wdata = 32'h2000; bus_wr = 1'b1; end
                209: begin bus_addr = 8'h60; bus_wdata = SYNC_B; bus_wr = 1'b1; end
                279: begin bus_addr = 8'h60; bus_wdata = SYNC_B_OFF; bus_wr = 1'b1; end
                349: begin bus_addr = 8'h60; bus_wdata = SYNC_A; bus_wr = 1'b1; end
                362: begin bus_addr = 8'h04; bus_wdata = 32'h4000_0000; bus_wr = 1'b1; end
                377: begin bus_addr = 8'h08; bus_wdata = 32'h4000_0000; bus_wr = 1'b1; end
                400: begin bus_addr = 8'h08; bus_wdata = 32'h1; bus_wr = 1'b1; end
                default: ;
            endcase
            if (t == 209) begin hs_hi = 0; vs_hi = 1; de_hi = 0; end
            if (t == 279) son = 0;
            if (t == 349) begin hs_hi = 1; vs_hi = 0; de_hi = 1; son = 1; end
            wr_prev = bus_wr;
        end
        bus_wr = 1'b0; bus_addr = 8'h90;

        // R11 soft reset
        wr(8'h04, 32'h8000_0000);
        @(negedge clk);
        rd(8'h10, rv); chk(rv == 0, "R11 frame word", rv, 0);
        rd(8'h00, rv); chk(rv == 32'h8000_0000, "R11 ctrl kept", rv, 32'h8000_0000);
        chk(frame_base == 0, "R11 base", frame_base, 0);
        chk(lcd_hsync && lcd_vsync && lcd_de && !pix_req, "R11 strobes",
            {lcd_hsync, lcd_vsync, lcd_de, pix_req}, 4'b1110);
        wr(8'h08, 32'h8000_0000);
        rd(8'h00, rv); chk(rv == 0, "R11 release", rv, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule